// File: doc/BRIEF.md
# Bit-Mapped Display Memory with Auto-Advancing Column Pointer

This block holds the dot pattern for a dot-matrix panel driver. The memory has 32 common rows and 128 columns. It has two sides that work independently.

The host side works with simple single-cycle strobes:
- One strobe picks one of four 8-row bands, called the row group.
- One strobe loads a 7-bit column pointer.
- The data strobes write or read one byte at a time. A byte covers eight vertically adjacent dots in the current group and column.

After each data access the column pointer moves one step to the right. It stops at the last column. The row group is never changed by this movement. To move the host to another band, it must issue both set commands again.

The scan side presents a row index and gets back, one clock later, all 128 dots of that common row for the segment drivers. A mirror input reverses the order in which columns reach the segment outputs. This lets the panel be mounted either way round.

Top module: `disp_bitmap_ram`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `rd_data` and `seg_out` are zero, both pointers are zero, and every stored dot reads as 0.
- R2: A cycle with `wr_stb` high stores `wr_data` bit k at common row (group×8 + k) of the column under the pointer. Bit 0 is the top row of the band.
- R3: A cycle with `rd_stb` high places the byte at the current group and column on `rd_data` in the next cycle, using the same bit order as R2. `rd_data` keeps its value in every cycle that follows a cycle without `rd_stb`.
- R4: Each cycle with `wr_stb` or `rd_stb` high moves the column pointer up by exactly one, as long as it is below 127.
- R5: When the column pointer is 127, a data access leaves it at 127. Later writes then overwrite column 127.
- R6: A `set_grp_stb` with `addr_val` from 0 to 3 loads that group. Column advancing, including reaching 127, never changes the group.
- R7: A `set_grp_stb` with `addr_val` above 3 is ignored, and the previous group stays in force.
- R8: A `set_col_stb` loads bits 6:0 of `addr_val` into the column pointer. Bit 7 is not used.
- R9: With `mirror` low, `seg_out[i]` one cycle after `scan_row` = r shows dot (row r, column i).
- R10: With `mirror` high, `seg_out[i]` one cycle after `scan_row` = r shows dot (row r, column 127−i).
- R11: When a write lands in the same cycle as a scan of the written row, that scan returns the old dots. The next scan of the row shows the new byte. Host accesses never hold off the scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| set_grp_stb | input | 1 | Load row group from `addr_val` |
| set_col_stb | input | 1 | Load column pointer from `addr_val` |
| addr_val | input | 8 | Value for the set commands |
| wr_stb | input | 1 | Write `wr_data` at group/column, then advance column |
| wr_data | input | 8 | Host write byte |
| rd_stb | input | 1 | Read byte at group/column, then advance column |
| rd_data | output | 8 | Registered host read byte |
| scan_row | input | 5 | Common row to scan out |
| mirror | input | 1 | Reverse column-to-segment order |
| seg_out | output | 128 | Registered segment dots for the scanned row |

## Verification
Two functions can fall in the same cycle: a host write into a row, and a scan of that same row. The bench provokes this by raising `wr_stb` on the cycle in which `scan_row` names a row inside the band being written. It checks the segment vector on the following cycle against the bench's model of the row before the write. It then scans the row again and expects the new byte to appear. The mirror mapping is judged against the same model with both settings of `mirror`.

// File: rtl/disp_bitmap_pkg.sv
package disp_bitmap_pkg;
    parameter int ROWS    = 32;
    parameter int COLS    = 128;
    parameter int BYTE_W  = 8;

    localparam int GROUPS = ROWS / BYTE_W;
    localparam int GRP_W  = $clog2(GROUPS);
    localparam int COL_W  = $clog2(COLS);
    localparam int ROW_W  = $clog2(ROWS);
    localparam int VAL_W  = 8;

    typedef logic [GRP_W-1:0]  grp_t;
    typedef logic [COL_W-1:0]  col_t;
    typedef logic [ROW_W-1:0]  row_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [ROWS-1:0]   colbits_t;
    typedef logic [COLS-1:0]   rowbits_t;

    typedef struct packed {
        grp_t grp;
        col_t col;
    } host_ptr_t;

    function automatic col_t col_step(input col_t c);
        return (c == col_t'(COLS - 1)) ? c : col_t'(c + 1'b1);
    endfunction

    function automatic logic grp_legal(input logic [VAL_W-1:0] v);
        return v < VAL_W'(GROUPS);
    endfunction
endpackage

// File: rtl/disp_ptr_ctrl.sv
module disp_ptr_ctrl
    import disp_bitmap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             set_grp,
    input  logic             set_col,
    input  logic [VAL_W-1:0] val,
    input  logic             access,
    output host_ptr_t        ptr
);
    host_ptr_t ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else begin
            if (set_grp && grp_legal(val))
                ptr_q.grp <= grp_t'(val);
            if (set_col)
                ptr_q.col <= col_t'(val[COL_W-1:0]);
            else if (access)
                ptr_q.col <= col_step(ptr_q.col);
        end
    end

    assign ptr = ptr_q;

    // R4
    col_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (access && !set_col && ptr_q.col != col_t'(COLS - 1))
            |=> ptr_q.col == $past(ptr_q.col) + 1'b1);

    // R5
    col_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (access && !set_col && ptr_q.col == col_t'(COLS - 1))
            |=> ptr_q.col == col_t'(COLS - 1));

    // R6
    grp_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !set_grp |=> $stable(ptr_q.grp));

    // R7
    bad_grp_chk: assert property (@(posedge clk) disable iff (rst)
        (set_grp && val >= VAL_W'(GROUPS)) |=> $stable(ptr_q.grp));
endmodule

// File: rtl/disp_bit_store.sv
module disp_bit_store
    import disp_bitmap_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  host_ptr_t ptr,
    input  logic      wr_en,
    input  byte_t     wr_byte,
    input  logic      rd_en,
    output byte_t     rd_byte,
    input  row_t      scan_row,
    output rowbits_t  scan_raw
);
    colbits_t cells_q [COLS];
    byte_t    rd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < COLS; c++)
                cells_q[c] <= '0;
        end else if (wr_en) begin
            cells_q[ptr.col][{ptr.grp, 3'b000} +: BYTE_W] <= wr_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_q <= '0;
        else if (rd_en)
            rd_q <= cells_q[ptr.col][{ptr.grp, 3'b000} +: BYTE_W];
    end

    assign rd_byte = rd_q;

    generate
        for (genvar c = 0; c < COLS; c++) begin : g_tap
            assign scan_raw[c] = cells_q[c][scan_row];
        end
    endgenerate

    // R3
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_q));
endmodule

// File: rtl/disp_seg_map.sv
module disp_seg_map
    import disp_bitmap_pkg::*;
(
    input  rowbits_t raw,
    input  logic     mirror,
    output rowbits_t seg
);
    generate
        for (genvar i = 0; i < COLS; i++) begin : g_seg
            assign seg[i] = mirror ? raw[COLS-1-i] : raw[i];
        end
    endgenerate
endmodule

// File: rtl/disp_bitmap_ram.sv
module disp_bitmap_ram
    import disp_bitmap_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         set_grp_stb,
    input  logic         set_col_stb,
    input  logic [7:0]   addr_val,
    input  logic         wr_stb,
    input  logic [7:0]   wr_data,
    input  logic         rd_stb,
    output logic [7:0]   rd_data,
    input  logic [4:0]   scan_row,
    input  logic         mirror,
    output logic [127:0] seg_out
);
    host_ptr_t ptr;
    rowbits_t  raw_row;
    rowbits_t  mapped_row;
    rowbits_t  seg_q;

    disp_ptr_ctrl u_ptr (
        .clk     (clk),
        .rst     (rst),
        .set_grp (set_grp_stb),
        .set_col (set_col_stb),
        .val     (addr_val),
        .access  (wr_stb | rd_stb),
        .ptr     (ptr)
    );

    disp_bit_store u_store (
        .clk      (clk),
        .rst      (rst),
        .ptr      (ptr),
        .wr_en    (wr_stb),
        .wr_byte  (wr_data),
        .rd_en    (rd_stb),
        .rd_byte  (rd_data),
        .scan_row (scan_row),
        .scan_raw (raw_row)
    );

    disp_seg_map u_map (
        .raw    (raw_row),
        .mirror (mirror),
        .seg    (mapped_row)
    );

    always_ff @(posedge clk) begin
        if (rst)
            seg_q <= '0;
        else
            seg_q <= mapped_row;
    end

    assign seg_out = seg_q;

    // R1
    rst_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> (seg_out == '0 && rd_data == '0));
endmodule

// File: tb/disp_bitmap_ram_tb.sv
module disp_bitmap_ram_tb;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         set_grp_stb = 1'b0, set_col_stb = 1'b0;
    logic [7:0]   addr_val = '0;
    logic         wr_stb = 1'b0, rd_stb = 1'b0;
    logic [7:0]   wr_data = '0;
    logic [7:0]   rd_data;
    logic [4:0]   scan_row = '0;
    logic         mirror = 1'b0;
    logic [127:0] seg_out;

    int checks = 0, errors = 0;
    logic [31:0] mdl [128];
    int bgrp = 0, bcol = 0;

    always #4 clk = ~clk;

    disp_bitmap_ram u_dut (.*);

    // {group, column, data}
    localparam logic [16:0] VEC [8] = '{
        {2'd0, 7'd0,   8'hA5}, {2'd1, 7'd5,   8'h3C},
        {2'd2, 7'd64,  8'hFF}, {2'd3, 7'd127, 8'h81},
        {2'd0, 7'd1,   8'h01}, {2'd1, 7'd100, 8'h80},
        {2'd3, 7'd0,   8'h5A}, {2'd2, 7'd126, 8'hC3}
    };

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] exp_seg(input int r, input logic m);
        logic [127:0] v;
        for (int i = 0; i < 128; i++)
            v[i] = m ? mdl[127-i][r] : mdl[i][r];
        return v;
    endfunction

    task automatic set_grp(input logic [7:0] v);
        @(negedge clk); set_grp_stb = 1'b1; addr_val = v;
        @(negedge clk); set_grp_stb = 1'b0;
        if (v < 4) bgrp = v;
    endtask

    task automatic set_col(input logic [7:0] v);
        @(negedge clk); set_col_stb = 1'b1; addr_val = v;
        @(negedge clk); set_col_stb = 1'b0;
        bcol = v[6:0];
    endtask

    task automatic step_col();
        if (bcol < 127) bcol++;
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); wr_stb = 1'b1; wr_data = d;
        @(negedge clk); wr_stb = 1'b0;
        mdl[bcol][bgrp*8 +: 8] = d;
        step_col();
    endtask

    task automatic rd_chk(input string req);
        @(negedge clk); rd_stb = 1'b1;
        @(negedge clk); rd_stb = 1'b0;
        check(req, 128'(rd_data), 128'(mdl[bcol][bgrp*8 +: 8]));
        step_col();
    endtask

    task automatic scan_chk(input string req, input int r, input logic m);
        @(negedge clk); scan_row = 5'(r); mirror = m;
        @(negedge clk);
        check(req, seg_out, exp_seg(r, m));
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] hold;
        logic [127:0] old_row;
        for (int c = 0; c < 128; c++) mdl[c] = '0;
        repeat (3) @(negedge clk);
        check("R1 seg", seg_out, '0);
        check("R1 rd", 128'(rd_data), '0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 seg after", seg_out, '0);
        rd_chk("R1 cleared cell g0c0");

        // table walk: R2 write, R3 read back
        for (int k = 0; k < 8; k++) begin
            set_grp(8'(VEC[k][16:15]));
            set_col(8'(VEC[k][14:8]));
            wr(VEC[k][7:0]);
            set_col(8'(VEC[k][14:8]));
            rd_chk("R2 R3 table readback");
        end

        // R3 hold without strobe
        hold = rd_data;
        repeat (3) @(negedge clk);
        check("R3 hold", 128'(rd_data), 128'(hold));

        // R4 increment
        set_grp(8'd2); set_col(8'd20);
        wr(8'h11); wr(8'h22); wr(8'h33);
        set_col(8'd21);
        rd_chk("R4 second byte"); rd_chk("R4 third byte");

        // R5 saturation
        set_grp(8'd1); set_col(8'd126);
        wr(8'h12); wr(8'h34); wr(8'h56);
        set_col(8'd126);
        rd_chk("R5 col126"); rd_chk("R5 col127 last write"); rd_chk("R5 col127 held");

        // R6 group unchanged after saturation; next group untouched
        wr(8'h9E);
        set_grp(8'd2); set_col(8'd0);
        rd_chk("R6 neighbour group intact");
        set_grp(8'd1); set_col(8'd127);
        rd_chk("R6 group kept at sat");

        // R7 illegal group ignored
        set_grp(8'd3); set_grp(8'd6); set_col(8'd10);
        wr(8'h77);
        set_grp(8'd3); set_col(8'd10);
        rd_chk("R7 group kept");
        set_grp(8'd0); set_col(8'd10);
        rd_chk("R7 other group");

        // R8 column bit7 unused
        set_grp(8'd0); set_col(8'h85);
        wr(8'h6B);
        set_col(8'd5);
        rd_chk("R8 masked column");

        // R9 / R10 scan with both mappings
        for (int r = 0; r < 32; r += 7) begin
            scan_chk("R9 normal order", r, 1'b0);
            scan_chk("R10 mirrored", r, 1'b1);
        end
        scan_chk("R9 row 31", 31, 1'b0);
        scan_chk("R10 row 8", 8, 1'b1);

        // R11 collision of write and scan
        set_grp(8'd2); set_col(8'd40);
        old_row = exp_seg(19, 1'b0);
        @(negedge clk);
        scan_row = 5'd19; mirror = 1'b0; wr_stb = 1'b1; wr_data = 8'hFF;
        @(negedge clk);
        wr_stb = 1'b0;
        mdl[bcol][bgrp*8 +: 8] = 8'hFF;
        step_col();
        check("R11 old data in collision", seg_out, old_row);
        @(negedge clk);
        check("R11 new data next scan", seg_out, exp_seg(19, 1'b0));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule